// File: doc/BRIEF.md
# Dual-Channel Thermal Alarm Controller

This block watches two temperature-code channels and turns their readings into alarms. A free-running tick generator asks the converter for a new sample at a programmable interval. When at least one channel is running hot, it switches to a second, usually shorter, interval. Each returned 12-bit code is stored per channel and compared against two limits of that channel: a warning limit and a shutdown limit. Codes rise with temperature. A reading counts as over a limit only when it is strictly greater than it.

Every limit has its own debounce counter. An alarm fires only after a programmed number of consecutive readings over the limit. Warning, shutdown and end-of-conversion events set sticky pending bits, which are cleared by writing 1. These bits are gated by an enable mask onto one interrupt line. A shutdown event also latches a per-channel shutdown state. That state can be steered to a reset-unit output, to a pin output, or to both. The pin output has a programmable active level.

Software configures the block over a simple 32-bit register bus, with a byte address and a write strobe. The read data is combinational.

Top module: `thermal_alarm_ctrl`

## Requirements
- R1: After reset the pending register (0x0C) reads 0, irq_o is 0, shut_rst_o is 0, shut_pin_o is 1 (the polarity bit resets to 0, so the pin idles high), sample_req is 0 and both data registers read 0.
- R2: A conversion (conv_valid with conv_chan selecting channel 0 or 1) stores conv_code in that channel's data register (channel 0 at 0x10, channel 1 at 0x14). This happens even when the channel is disabled.
- R3: A code is over a limit only when it is strictly greater than the limit. A code equal to the limit counts as not over. Warn limits are at 0x18 and 0x1C, shutdown limits at 0x20 and 0x24.
- R4: Each warn counter (count at 0x30) and each shutdown counter (count at 0x34) rises by one per accepted over-limit sample and returns to 0 on a sample that is not over. The event fires once, on the sample that brings the counter to the programmed count; a count of 0 acts as 1. Warn pending bits are [1:0] and shutdown pending bits are [3:2], one per channel.
- R5: Pending bit 4 (end of conversion) sets on every conversion result.
- R6: Writing 1 to a pending bit at 0x0C clears it. An event arriving in the same cycle as the clear wins, and the bit stays set.
- R7: irq_o is high exactly when some pending bit is set whose enable bit is set in the enable register at 0x08, which uses the same bit layout.
- R8: While auto-enable (control 0x00 bit 0) is set, sample_req pulses once every P cycles. P is the period at 0x28 when no active channel's latest sample exceeded one of its limits, and the hot period at 0x2C otherwise. With auto-enable clear, sample_req stays low.
- R9: A shutdown event latches that channel's shutdown state. The latch drives shut_rst_o when routing bit 0 or 1 (register 0x04) is set for the channel, and the pin when routing bit 2 or 3 is set. It holds across later cool samples and clears only on reset or when auto-enable is cleared.
- R10: Control bit 3 selects the pin level. With 1 the pin is high when active and low otherwise; with 0 the pin is low when active and high otherwise.
- R11: A channel is evaluated only when auto-enable and its enable bit (control bits 1 and 2) are both set. Otherwise its counters stay at 0 and it raises no warn or shutdown event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| sample_req | output | 1 | One-cycle request for a new conversion |
| conv_valid | input | 1 | Conversion result valid |
| conv_chan | input | 1 | Channel of the result |
| conv_code | input | 12 | Conversion code |
| irq_o | output | 1 | Combined interrupt |
| shut_rst_o | output | 1 | Shutdown request to the reset unit, active high |
| shut_pin_o | output | 1 | Shutdown pin, level set by polarity |

## Verification
Two functions can meet in one cycle: a software write-1-to-clear of the pending register, and a hardware event that sets the same bit. The bench provokes this by driving a pending-register write that clears the end-of-conversion bit on the same clock edge as a conversion result. It then reads the register back and expects the bit still set. A plain clear on a quiet cycle, which must drop the bit, is checked alongside.

// File: rtl/ta_pkg.sv
package ta_pkg;
  localparam int NCH    = 2;
  localparam int CH_W   = 1;
  localparam int CODE_W = 12;
  localparam int DEB_W  = 8;
  localparam int PER_W  = 32;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int PEND_W = 2 * NCH + 1;

  localparam logic [ADDR_W-1:0] RA_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] RA_ROUTE = 8'h04;
  localparam logic [ADDR_W-1:0] RA_IEN   = 8'h08;
  localparam logic [ADDR_W-1:0] RA_PEND  = 8'h0C;
  localparam logic [ADDR_W-1:0] RA_DATA0 = 8'h10;
  localparam logic [ADDR_W-1:0] RA_WARN0 = 8'h18;
  localparam logic [ADDR_W-1:0] RA_SHUT0 = 8'h20;
  localparam logic [ADDR_W-1:0] RA_PER   = 8'h28;
  localparam logic [ADDR_W-1:0] RA_PERH  = 8'h2C;
  localparam logic [ADDR_W-1:0] RA_DEBW  = 8'h30;
  localparam logic [ADDR_W-1:0] RA_DEBS  = 8'h34;

  function automatic logic ta_exceeds(logic [CODE_W-1:0] code, logic [CODE_W-1:0] lim);
    return code > lim;
  endfunction

  function automatic logic [DEB_W-1:0] ta_deb_limit(logic [DEB_W-1:0] deb);
    return (deb == '0) ? DEB_W'(1) : deb;
  endfunction

  function automatic logic [PER_W-1:0] ta_period_limit(logic [PER_W-1:0] p);
    return (p == '0) ? '0 : p - PER_W'(1);
  endfunction
endpackage

// File: rtl/ta_tick_gen.sv
module ta_tick_gen
  import ta_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hot,
  input  logic [PER_W-1:0] period,
  input  logic [PER_W-1:0] period_hot,
  output logic             req
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] lim;

  assign lim = ta_period_limit(hot ? period_hot : period);
  assign req = run && (cnt_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || req)   cnt_q <= '0;
    else                    cnt_q <= cnt_q + PER_W'(1);
  end

  assert_start_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> cnt_q == '0);
endmodule

// File: rtl/ta_debounce.sv
module ta_debounce
  import ta_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              valid,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] limit,
  input  logic [DEB_W-1:0]  deb,
  output logic              fire,
  output logic              over_q
);
  logic [DEB_W-1:0] cnt_q;
  logic [DEB_W-1:0] eff;
  logic             over;
  logic             below_eff;

  assign over      = ta_exceeds(code, limit);
  assign eff       = ta_deb_limit(deb);
  assign below_eff = cnt_q < eff;
  assign fire      = active && valid && over && below_eff &&
                     ({1'b0, cnt_q} + (DEB_W+1)'(1) == {1'b0, eff});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      over_q <= 1'b0;
    end else if (!active) begin
      cnt_q  <= '0;
      over_q <= 1'b0;
    end else if (valid) begin
      over_q <= over;
      if (!over)          cnt_q <= '0;
      else if (below_eff) cnt_q <= cnt_q + DEB_W'(1);
    end
  end

  assert_cool_resets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && valid && !over) |=> cnt_q == '0);
  assert_idle_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt_q == '0 && !over_q));
endmodule

// File: rtl/ta_chan_eval.sv
module ta_chan_eval
  import ta_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              valid,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] warn_lim,
  input  logic [CODE_W-1:0] shut_lim,
  input  logic [DEB_W-1:0]  deb_warn,
  input  logic [DEB_W-1:0]  deb_shut,
  output logic              warn_fire,
  output logic              shut_fire,
  output logic              hot
);
  logic warn_over, shut_over;

  ta_debounce u_warn (
    .clk(clk), .rst_n(rst_n), .active(active), .valid(valid), .code(code),
    .limit(warn_lim), .deb(deb_warn), .fire(warn_fire), .over_q(warn_over));

  ta_debounce u_shut (
    .clk(clk), .rst_n(rst_n), .active(active), .valid(valid), .code(code),
    .limit(shut_lim), .deb(deb_shut), .fire(shut_fire), .over_q(shut_over));

  assign hot = warn_over | shut_over;
endmodule

// File: rtl/thermal_alarm_ctrl.sv
module thermal_alarm_ctrl
  import ta_pkg::*;
#(
  parameter logic [PER_W-1:0] PERIOD_RST     = 32'd16,
  parameter logic [PER_W-1:0] PERIOD_HOT_RST = 32'd8,
  parameter logic [DEB_W-1:0] DEB_RST        = 8'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sample_req,
  input  logic              conv_valid,
  input  logic [CH_W-1:0]   conv_chan,
  input  logic [CODE_W-1:0] conv_code,
  output logic              irq_o,
  output logic              shut_rst_o,
  output logic              shut_pin_o
);
  logic              auto_q, pol_q;
  logic [NCH-1:0]    src_en_q, rst_route_q, pin_route_q;
  logic [PEND_W-1:0] ien_q, pend_q, set_vec, clr_vec;
  logic [CODE_W-1:0] data_q [NCH];
  logic [CODE_W-1:0] warn_q [NCH];
  logic [CODE_W-1:0] shut_q [NCH];
  logic [PER_W-1:0]  per_q, perh_q;
  logic [DEB_W-1:0]  debw_q, debs_q;
  logic [NCH-1:0]    warn_fire, shut_fire, ch_hot, shut_lat_q;
  logic              pin_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q <= 1'b0; pol_q <= 1'b0; src_en_q <= '0;
      rst_route_q <= '0; pin_route_q <= '0; ien_q <= '0;
      per_q <= PERIOD_RST; perh_q <= PERIOD_HOT_RST;
      debw_q <= DEB_RST; debs_q <= DEB_RST;
      for (int i = 0; i < NCH; i++) begin
        data_q[i] <= '0; warn_q[i] <= '1; shut_q[i] <= '1;
      end
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          RA_CTRL:  begin
            auto_q <= bus_wdata[0]; src_en_q <= bus_wdata[NCH:1]; pol_q <= bus_wdata[NCH+1];
          end
          RA_ROUTE: begin
            rst_route_q <= bus_wdata[NCH-1:0]; pin_route_q <= bus_wdata[2*NCH-1:NCH];
          end
          RA_IEN:   ien_q  <= bus_wdata[PEND_W-1:0];
          RA_PER:   per_q  <= bus_wdata;
          RA_PERH:  perh_q <= bus_wdata;
          RA_DEBW:  debw_q <= bus_wdata[DEB_W-1:0];
          RA_DEBS:  debs_q <= bus_wdata[DEB_W-1:0];
          default: ;
        endcase
        for (int i = 0; i < NCH; i++) begin
          if (bus_addr == RA_WARN0 + ADDR_W'(4 * i)) warn_q[i] <= bus_wdata[CODE_W-1:0];
          if (bus_addr == RA_SHUT0 + ADDR_W'(4 * i)) shut_q[i] <= bus_wdata[CODE_W-1:0];
        end
      end
      for (int i = 0; i < NCH; i++)
        if (conv_valid && conv_chan == CH_W'(i)) data_q[i] <= conv_code;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ta_chan_eval u_ch (
      .clk(clk), .rst_n(rst_n),
      .active(auto_q && src_en_q[g]),
      .valid(conv_valid && conv_chan == CH_W'(g)),
      .code(conv_code), .warn_lim(warn_q[g]), .shut_lim(shut_q[g]),
      .deb_warn(debw_q), .deb_shut(debs_q),
      .warn_fire(warn_fire[g]), .shut_fire(shut_fire[g]), .hot(ch_hot[g]));
  end

  ta_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .run(auto_q), .hot(|ch_hot),
    .period(per_q), .period_hot(perh_q), .req(sample_req));

  assign set_vec = {conv_valid, shut_fire, warn_fire};
  assign clr_vec = (bus_wr && bus_addr == RA_PEND) ? bus_wdata[PEND_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      shut_lat_q <= '0;
    end else begin
      pend_q     <= (pend_q & ~clr_vec) | set_vec;
      shut_lat_q <= auto_q ? (shut_lat_q | shut_fire) : '0;
    end
  end

  assign irq_o      = |(pend_q & ien_q);
  assign shut_rst_o = |(shut_lat_q & rst_route_q);
  assign pin_active = |(shut_lat_q & pin_route_q);
  assign shut_pin_o = ~(pin_active ^ pol_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_CTRL:  bus_rdata = DATA_W'({pol_q, src_en_q, auto_q});
      RA_ROUTE: bus_rdata = DATA_W'({pin_route_q, rst_route_q});
      RA_IEN:   bus_rdata = DATA_W'(ien_q);
      RA_PEND:  bus_rdata = DATA_W'(pend_q);
      RA_DATA0: bus_rdata = DATA_W'(data_q[0]);
      RA_DATA0 + 8'h04: bus_rdata = DATA_W'(data_q[1]);
      RA_WARN0: bus_rdata = DATA_W'(warn_q[0]);
      RA_WARN0 + 8'h04: bus_rdata = DATA_W'(warn_q[1]);
      RA_SHUT0: bus_rdata = DATA_W'(shut_q[0]);
      RA_SHUT0 + 8'h04: bus_rdata = DATA_W'(shut_q[1]);
      RA_PER:   bus_rdata = per_q;
      RA_PERH:  bus_rdata = perh_q;
      RA_DEBW:  bus_rdata = DATA_W'(debw_q);
      RA_DEBS:  bus_rdata = DATA_W'(debs_q);
      default:  bus_rdata = '0;
    endcase
  end

  assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));
  assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0));
  assert_latch_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    auto_q |=> ((shut_lat_q & $past(shut_lat_q)) == $past(shut_lat_q)));
endmodule

// File: tb/thermal_alarm_ctrl_tb.sv
module thermal_alarm_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h00, A_ROUTE = 8'h04, A_IEN = 8'h08, A_PEND = 8'h0C,
                         A_D0 = 8'h10, A_D1 = 8'h14, A_W0 = 8'h18, A_W1 = 8'h1C,
                         A_S0 = 8'h20, A_S1 = 8'h24, A_PER = 8'h28, A_PERH = 8'h2C,
                         A_DBW = 8'h30, A_DBS = 8'h34;
  // {chan, code, expected warn pend [1:0], expected shut pend [3:2]}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 12'h801, 2'b00, 2'b00},
    {1'b0, 12'h800, 2'b00, 2'b00},
    {1'b0, 12'hA01, 2'b00, 2'b00},
    {1'b0, 12'hA01, 2'b01, 2'b00},
    {1'b1, 12'h401, 2'b01, 2'b00},
    {1'b0, 12'hA01, 2'b01, 2'b01},
    {1'b1, 12'h501, 2'b11, 2'b01},
    {1'b1, 12'h300, 2'b11, 2'b01}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sample_req, conv_valid = 1'b0, irq_o, shut_rst_o, shut_pin_o;
  logic conv_chan = 1'b0;
  logic [11:0] conv_code = '0;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_alarm_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sample_req(sample_req),
    .conv_valid(conv_valid), .conv_chan(conv_chan), .conv_code(conv_code),
    .irq_o(irq_o), .shut_rst_o(shut_rst_o), .shut_pin_o(shut_pin_o));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic conv(logic ch, logic [11:0] c);
    @(negedge clk); conv_valid = 1'b1; conv_chan = ch; conv_code = c;
    @(negedge clk); conv_valid = 1'b0;
  endtask

  task automatic measure(output int n);
    int g = 0;
    while (!sample_req && g < 100) begin @(negedge clk); g++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!sample_req && n < 100);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(A_PEND, r); chk("R1 pend", r, 0);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 shut_rst", 32'(shut_rst_o), 0);
    chk("R1 shut_pin", 32'(shut_pin_o), 1);
    chk("R1 sample_req", 32'(sample_req), 0);
    rd(A_D0, r); chk("R1 data0", r, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A_D1, r); chk("R1 data1", r, 0);

    wr(A_W0, 32'h800); wr(A_S0, 32'hA00); wr(A_W1, 32'h400); wr(A_S1, 32'h500);
    wr(A_DBW, 2); wr(A_DBS, 3); wr(A_PER, 5); wr(A_PERH, 3);
    wr(A_ROUTE, 32'h9); wr(A_CTRL, 32'hF);

    // R3, R4, R5, R2: table walk
    foreach (VEC[i]) begin
      conv(VEC[i][16], VEC[i][15:4]);
      rd(A_PEND, r); chk("R4 R3 R5 pend", r, {27'd0, 1'b1, VEC[i][1:0], VEC[i][3:2]});
      rd(VEC[i][16] ? A_D1 : A_D0, r); chk("R2 data", r, 32'(VEC[i][15:4]));
    end
    chk("R9 shut_rst after ch0 shutdown", 32'(shut_rst_o), 1);
    chk("R10 pin idle low with polarity 1", 32'(shut_pin_o), 0);

    // R8 periods: ch0 last sample hot
    measure(n); chk("R8 hot period", 32'(n), 3);
    conv(1'b0, 12'h100);
    measure(n); chk("R8 normal period", 32'(n), 5);
    chk("R9 latch holds after cool sample", 32'(shut_rst_o), 1);

    // R7 interrupt gating
    chk("R7 irq masked", 32'(irq_o), 0);
    wr(A_IEN, 32'h10); chk("R7 irq enabled", 32'(irq_o), 1);
    wr(A_PEND, 32'h1F);
    rd(A_PEND, r); chk("R6 clear all", r, 0);
    chk("R7 irq after clear", 32'(irq_o), 0);

    // R6 collision: clear eoc while a conversion arrives
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_PEND; bus_wdata = 32'h10;
    conv_valid = 1'b1; conv_chan = 1'b0; conv_code = 12'h100;
    @(negedge clk); bus_wr = 1'b0; conv_valid = 1'b0;
    rd(A_PEND, r); chk("R6 set wins over clear", r, 32'h10);
    wr(A_PEND, 32'h10);
    rd(A_PEND, r); chk("R6 plain clear", r, 0);

    // R10 polarity
    wr(A_ROUTE, 32'hD); chk("R10 pin active high", 32'(shut_pin_o), 1);
    wr(A_CTRL, 32'h7); chk("R10 pin active low", 32'(shut_pin_o), 0);

    // R9 clear by auto-enable off, R8 idle
    wr(A_CTRL, 32'h0);
    @(negedge clk);
    chk("R9 latch cleared rst", 32'(shut_rst_o), 0);
    chk("R9 latch cleared pin", 32'(shut_pin_o), 1);
    n = 0;
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (sample_req) n++; end
    chk("R8 no requests when off", 32'(n), 0);

    // R11 disabled channel
    wr(A_CTRL, 32'h3); wr(A_DBW, 1); wr(A_PEND, 32'h1F);
    conv(1'b1, 12'hFFF);
    rd(A_D1, r); chk("R11 R2 data stored while disabled", r, 32'hFFF);
    rd(A_PEND, r); chk("R11 no event from disabled channel", r, 32'h10);
    wr(A_CTRL, 32'h7); wr(A_PEND, 32'h1F);
    conv(1'b1, 12'hFFF);
    rd(A_PEND, r); chk("R11 R4 event once enabled", r, 32'h12);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule